// File: doc/BRIEF.md
# Selectable Pin Interrupt Controller

This block watches a wide vector of general-purpose pins and turns activity on chosen pins into separate interrupt lines. It has a fixed number of channels (eight by default). Each channel is steered to one pin by a 6-bit index supplied from outside the block. Pins of the first port occupy indices 0 to 23, the second port 24 to 55 and the third port 56 upward. Pin inputs pass through a two-stage synchronizer. Each synchronized value is then compared with its value one cycle earlier to find rising and falling transitions.

Every channel runs in one of two modes. In edge mode the channel latches an armed rising and/or falling transition into a sticky status bit, which software clears by writing one. In level mode the same two enable bits are read differently: the rising enable switches the channel on, and the falling enable picks the active polarity. The status bit then follows the pin. Two extra capture registers record every rising and every falling transition seen on each channel's pin, whatever the enables say. Software reaches all of this through a simple 32-bit word-addressed register port. Enables change only through separate write-one-to-set and write-one-to-clear locations.

Top module: `pin_irq_router`

## Requirements
- R1: After reset, every register reads 0 and every `irq_o` bit is 0.
- R2: Channel c observes pin `pins_i[sel_i[6c+5:6c]]`.
- R3: Word address 0 holds the mode bits (bit c = 1 selects level mode for channel c, 0 selects edge mode). It is read/write in bits [7:0], and bits above 7 read as 0.
- R4: Writing ones to address 2 sets rising enables and to address 3 clears them. Addresses 5 and 6 do the same for the falling enables. Rising enables read back at address 1 and falling enables at address 4. Writes to addresses 1 and 4 have no effect, and addresses 2, 3, 5 and 6 read as 0.
- R5: In edge mode the status bit (address 9) sets on a transition whose direction is enabled and holds until 1 is written to that bit. A transition in a direction that is not enabled leaves it unchanged.
- R6: In level mode the status bit equals rising-enable AND (pin == falling-enable), so a falling-enable of 1 means active high and 0 means active low. Writing 1 to the status bit has no lasting effect.
- R7: Address 7 (rise capture) and address 8 (fall capture) set on every rising or falling transition of the channel's pin regardless of mode or enables. Writing 1 clears a bit.
- R8: `irq_o[c]` equals status bit c as read at address 9.
- R9: A pin transition applied before clock edge k shows in status after edge k+2 and not after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 64 | Asynchronous pin vector |
| sel_i | input | 48 | Packed 6-bit pin index per channel, channel c at bits [6c+5:6c] |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| irq_o | output | 8 | Per-channel interrupt outputs |

## Verification
The hardest case to reach is several channels pointing at the same pin with different modes and enable sets, while enables change and write-one-clears arrive between transitions. The level channels must then track the pin while the edge channels keep stale sticky bits. The stimulus makes this happen by drawing the channel indices from a narrow pin range, so channels often share pins. It toggles one random pin at a time, mixes in random set/clear and clear-status writes, and checks the captures, status and outputs against a bench model after each step.

// File: rtl/pir_pkg.sv
package pir_pkg;
   localparam int unsigned REG_AW = 4;

   typedef enum logic [REG_AW-1:0] {
      RA_MODE  = 4'd0,
      RA_ENR   = 4'd1,
      RA_SETR  = 4'd2,
      RA_CLRR  = 4'd3,
      RA_ENF   = 4'd4,
      RA_SETF  = 4'd5,
      RA_CLRF  = 4'd6,
      RA_RISE  = 4'd7,
      RA_FALL  = 4'd8,
      RA_STAT  = 4'd9
   } pir_addr_e;
endpackage

// File: rtl/pir_sync.sv
module pir_sync #(
   parameter int unsigned W      = 64,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] cur_o,
   output logic [W-1:0] prev_o
);
   logic [W-1:0] stg [STAGES];
   logic [W-1:0] prev_q;

   generate
      if (STAGES < 1) begin : g_bad
         $error("pir_sync needs at least one stage");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
         prev_q <= '0;
      end else begin
         stg[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         prev_q <= stg[STAGES-1];
      end
   end

   assign cur_o  = stg[STAGES-1];
   assign prev_o = prev_q;
endmodule

// File: rtl/pir_channel.sv
module pir_channel (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_mode,
   input  logic en_r,
   input  logic en_f,
   input  logic pin_now,
   input  logic pin_prev,
   input  logic clr_rise,
   input  logic clr_fall,
   input  logic clr_st,
   output logic rise_q,
   output logic fall_q,
   output logic st_q
);
   logic rise_evt, fall_evt;

   assign rise_evt = pin_now & ~pin_prev;
   assign fall_evt = ~pin_now & pin_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_q <= 1'b0;
         fall_q <= 1'b0;
         st_q   <= 1'b0;
      end else begin
         rise_q <= rise_evt | (rise_q & ~clr_rise);
         fall_q <= fall_evt | (fall_q & ~clr_fall);
         if (lvl_mode)
            st_q <= en_r & (pin_now == en_f);
         else
            st_q <= (en_r & rise_evt) | (en_f & fall_evt) | (st_q & ~clr_st);
      end
   end
endmodule

// File: rtl/pin_irq_router.sv
module pin_irq_router
   import pir_pkg::*;
#(
   parameter int unsigned NCH         = 8,
   parameter int unsigned NPIN        = 64,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DW          = 32,
   localparam int unsigned SELW       = $clog2(NPIN)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NPIN-1:0]     pins_i,
   input  logic [NCH*SELW-1:0] sel_i,
   input  logic                reg_we,
   input  logic [REG_AW-1:0]   reg_addr,
   input  logic [DW-1:0]       reg_wdata,
   output logic [DW-1:0]       reg_rdata,
   output logic [NCH-1:0]      irq_o
);
   generate
      if (NCH > DW) begin : g_chk_nch
         $error("channel count exceeds register width");
      end
      if (NPIN < 2) begin : g_chk_npin
         $error("need at least two pins");
      end
   endgenerate

   logic [NPIN-1:0] pin_cur, pin_prev;
   logic [NCH-1:0]  mode_q, enr_q, enf_q;
   logic [NCH-1:0]  rise_vec, fall_vec, st_vec;
   logic [NCH-1:0]  wmask, set_r, clr_r, set_f, clr_f, clr_rise, clr_fall, clr_st;

   pir_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) sync_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    (pins_i),
      .cur_o  (pin_cur),
      .prev_o (pin_prev)
   );

   assign wmask    = reg_wdata[NCH-1:0];
   assign set_r    = (reg_we && reg_addr == RA_SETR) ? wmask : '0;
   assign clr_r    = (reg_we && reg_addr == RA_CLRR) ? wmask : '0;
   assign set_f    = (reg_we && reg_addr == RA_SETF) ? wmask : '0;
   assign clr_f    = (reg_we && reg_addr == RA_CLRF) ? wmask : '0;
   assign clr_rise = (reg_we && reg_addr == RA_RISE) ? wmask : '0;
   assign clr_fall = (reg_we && reg_addr == RA_FALL) ? wmask : '0;
   assign clr_st   = (reg_we && reg_addr == RA_STAT) ? wmask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         enr_q  <= '0;
         enf_q  <= '0;
      end else begin
         if (reg_we && reg_addr == RA_MODE) mode_q <= wmask;
         enr_q <= (enr_q | set_r) & ~clr_r;
         enf_q <= (enf_q | set_f) & ~clr_f;
      end
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [SELW-1:0] sel;
      logic            now_b, prev_b;

      assign sel    = sel_i[c*SELW +: SELW];
      assign now_b  = (32'(sel) < NPIN) ? pin_cur[sel]  : 1'b0;
      assign prev_b = (32'(sel) < NPIN) ? pin_prev[sel] : 1'b0;

      pir_channel ch_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .lvl_mode (mode_q[c]),
         .en_r     (enr_q[c]),
         .en_f     (enf_q[c]),
         .pin_now  (now_b),
         .pin_prev (prev_b),
         .clr_rise (clr_rise[c]),
         .clr_fall (clr_fall[c]),
         .clr_st   (clr_st[c]),
         .rise_q   (rise_vec[c]),
         .fall_q   (fall_vec[c]),
         .st_q     (st_vec[c])
      );
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_MODE: reg_rdata[NCH-1:0] = mode_q;
         RA_ENR:  reg_rdata[NCH-1:0] = enr_q;
         RA_ENF:  reg_rdata[NCH-1:0] = enf_q;
         RA_RISE: reg_rdata[NCH-1:0] = rise_vec;
         RA_FALL: reg_rdata[NCH-1:0] = fall_vec;
         RA_STAT: reg_rdata[NCH-1:0] = st_vec;
         default: reg_rdata = '0;
      endcase
   end

   assign irq_o = st_vec;
endmodule

// File: rtl/pin_irq_router_chk.sv
module pin_irq_router_chk #(
   parameter int unsigned NCH = 8,
   parameter int unsigned DW  = 32
) (
   input logic           clk,
   input logic           rst_n,
   input logic           reg_we,
   input logic [3:0]     reg_addr,
   input logic [DW-1:0]  reg_wdata,
   input logic [DW-1:0]  reg_rdata,
   input logic [NCH-1:0] irq_o,
   input logic [NCH-1:0] mode_q,
   input logic [NCH-1:0] enr_q,
   input logic [NCH-1:0] rise_vec
);
   logic [NCH-1:0] st_clr, rise_clr;
   assign st_clr   = (reg_we && reg_addr == 4'd9) ? reg_wdata[NCH-1:0] : '0;
   assign rise_clr = (reg_we && reg_addr == 4'd7) ? reg_wdata[NCH-1:0] : '0;

   assert_irq_reset_R1: assert property (@(posedge clk) !rst_n |-> irq_o == '0);

   assert_setclr_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 4'd2 || reg_addr == 4'd3 || reg_addr == 4'd5 || reg_addr == 4'd6)
      |-> reg_rdata == '0);

   assert_enable_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_we |=> $stable(enr_q));

   assert_edge_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(irq_o) & ~$past(mode_q) & ~$past(st_clr)) & ~irq_o) == '0));

   assert_level_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((irq_o & $past(mode_q & ~enr_q)) == '0));

   assert_capture_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(rise_vec) & ~$past(rise_clr)) & ~rise_vec) == '0));
endmodule

bind pin_irq_router pin_irq_router_chk #(.NCH(NCH), .DW(DW)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .irq_o     (irq_o),
   .mode_q    (mode_q),
   .enr_q     (enr_q),
   .rise_vec  (rise_vec)
);

// File: tb/pin_irq_router_tb_top.sv
module pin_irq_router_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] pins = '0;
   logic [47:0] sel_i;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [7:0]  irq_o;

   logic [5:0]  selv [8];
   logic [7:0]  m_mode, m_enr, m_enf, m_rise, m_fall, m_st;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   always_comb for (int c = 0; c < 8; c++) sel_i[c*6 +: 6] = selv[c];

   pin_irq_router dut_i (
      .clk(clk), .rst_n(rst_n), .pins_i(pins), .sel_i(sel_i),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_o(irq_o)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic settle();
      repeat (4) @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [7:0] lvl_exp();
      logic [7:0] r;
      for (int c = 0; c < 8; c++) r[c] = m_enr[c] & (pins[selv[c]] == m_enf[c]);
      return r;
   endfunction

   function automatic logic [7:0] st_exp();
      return (m_st & ~m_mode) | (lvl_exp() & m_mode);
   endfunction

   task automatic full_check(input string where);
      logic [31:0] v;
      rd(4'd7, v); chk({"R7 rise ", where}, v, {24'd0, m_rise});
      rd(4'd8, v); chk({"R7 fall ", where}, v, {24'd0, m_fall});
      rd(4'd9, v); chk({"R5/R6 status ", where}, v, {24'd0, st_exp()});
      chk({"R8/R2 irq ", where}, {24'd0, irq_o}, {24'd0, st_exp()});
   endtask

   task automatic toggle_pin(input int k);
      logic nv;
      nv = ~pins[k];
      @(negedge clk);
      pins[k] = nv;
      for (int c = 0; c < 8; c++) if (selv[c] == 6'(k)) begin
         if (nv) begin m_rise[c] = 1'b1; if (m_enr[c]) m_st[c] = 1'b1; end
         else    begin m_fall[c] = 1'b1; if (m_enf[c]) m_st[c] = 1'b1; end
      end
      settle();
   endtask

   task automatic batch(input int steps, input int lo);
      logic [31:0] r;
      for (int c = 0; c < 8; c++) selv[c] = 6'(lo + ($urandom % 8));
      m_mode = 8'($urandom);
      wr(4'd0, {24'd0, m_mode});
      wr(4'd3, 32'hFF); wr(4'd6, 32'hFF);
      m_enr = 8'($urandom); m_enf = 8'($urandom);
      wr(4'd2, {24'd0, m_enr}); wr(4'd5, {24'd0, m_enf});
      settle();
      wr(4'd7, 32'hFF); wr(4'd8, 32'hFF); wr(4'd9, 32'hFF);
      m_rise = '0; m_fall = '0; m_st = '0;
      settle();
      full_check("batch start");
      for (int s = 0; s < steps; s++) begin
         r = $urandom % 10;
         if (r < 6) toggle_pin(lo + ($urandom % 8));
         else if (r == 6) begin
            logic [7:0] m; m = 8'($urandom);
            if ($urandom % 2) begin wr(4'd2, {24'd0, m}); m_enr |= m; end
            else begin wr(4'd3, {24'd0, m}); m_enr &= ~m; end
            settle();
         end else if (r == 7) begin
            logic [7:0] m; m = 8'($urandom);
            if ($urandom % 2) begin wr(4'd5, {24'd0, m}); m_enf |= m; end
            else begin wr(4'd6, {24'd0, m}); m_enf &= ~m; end
            settle();
         end else begin
            logic [7:0] m; logic [3:0] a;
            m = 8'($urandom); a = 4'(7 + ($urandom % 3));
            wr(a, {24'd0, m});
            if (a == 4'd7) m_rise &= ~m;
            else if (a == 4'd8) m_fall &= ~m;
            else m_st &= ~m;
            settle();
         end
         full_check("random step");
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd20240611));
      for (int c = 0; c < 8; c++) selv[c] = 6'(c);
      m_mode = '0; m_enr = '0; m_enf = '0; m_rise = '0; m_fall = '0; m_st = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      for (int a = 0; a < 10; a++) begin
         rd(4'(a), v); chk("R1 reset register", v, 32'd0);
      end
      chk("R1 reset irq", {24'd0, irq_o}, 32'd0);
      rst_n = 1'b1;

      // R3 mode readback
      wr(4'd0, 32'hFFFF_FF3C); rd(4'd0, v); chk("R3 mode readback", v, 32'h3C);
      wr(4'd0, 32'h0); rd(4'd0, v); chk("R3 mode cleared", v, 32'h0);

      // R4 set/clear enables
      wr(4'd2, 32'hA5); rd(4'd1, v); chk("R4 set rising", v, 32'hA5);
      wr(4'd3, 32'h05); rd(4'd1, v); chk("R4 clear rising", v, 32'hA0);
      wr(4'd1, 32'hFF); rd(4'd1, v); chk("R4 direct write ignored", v, 32'hA0);
      wr(4'd5, 32'h3C); wr(4'd6, 32'h0C); rd(4'd4, v); chk("R4 falling set/clear", v, 32'h30);
      wr(4'd4, 32'h00); rd(4'd4, v); chk("R4 falling direct write ignored", v, 32'h30);
      rd(4'd2, v); chk("R4 set reads zero", v, 32'h0);
      rd(4'd3, v); chk("R4 clear reads zero", v, 32'h0);
      rd(4'd5, v); chk("R4 set falling reads zero", v, 32'h0);
      rd(4'd6, v); chk("R4 clear falling reads zero", v, 32'h0);
      wr(4'd3, 32'hFF); wr(4'd6, 32'hFF);
      settle();
      wr(4'd7, 32'hFF); wr(4'd8, 32'hFF); wr(4'd9, 32'hFF);

      // R9 latency, channel 0 edge mode, rising only
      wr(4'd2, 32'h01);
      settle();
      @(negedge clk);
      pins[0] = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      chk("R9 not yet after two edges", {31'd0, irq_o[0]}, 32'd0);
      @(posedge clk); @(negedge clk);
      chk("R9 set after three edges", {31'd0, irq_o[0]}, 32'd1);
      settle();
      chk("R5 sticky holds", {31'd0, irq_o[0]}, 32'd1);
      wr(4'd9, 32'h01); settle();
      chk("R5 cleared by write one", {31'd0, irq_o[0]}, 32'd0);
      @(negedge clk); pins[0] = 1'b0; settle();
      chk("R5 disabled falling ignored", {31'd0, irq_o[0]}, 32'd0);
      rd(4'd8, v); chk("R7 fall captured without enable", v & 32'h1, 32'h1);

      // R6 level mode, channel 1, active low
      wr(4'd0, 32'h02); wr(4'd2, 32'h02); settle();
      chk("R6 active low asserted", {31'd0, irq_o[1]}, 32'd1);
      wr(4'd9, 32'h02); settle();
      chk("R6 clear write has no effect", {31'd0, irq_o[1]}, 32'd1);
      @(negedge clk); pins[1] = 1'b1; settle();
      chk("R6 inactive when pin high", {31'd0, irq_o[1]}, 32'd0);
      wr(4'd5, 32'h02); settle();
      chk("R6 active high asserted", {31'd0, irq_o[1]}, 32'd1);
      wr(4'd3, 32'h02); settle();
      chk("R6 off when rising enable cleared", {31'd0, irq_o[1]}, 32'd0);
      @(negedge clk); pins[1] = 1'b0; settle();

      // random batches; channels crowd onto few pins (R2)
      batch(80, 0);
      batch(80, 56);
      batch(80, 20);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule